// File: doc/BRIEF.md
# Per-CPU Banked Level-1 Interrupt Aggregator

This block gathers a set of level-sensitive interrupt sources, in groups of 32, and drives one request line per processor. Every processor owns a private register window with its own bank of enable words. A processor's line goes high while at least one source is both asserted and enabled in that processor's bank. All banks see the same source levels, which pass through a two-flop synchroniser.

Software uses a plain read/write register bus. Within a window, all enable words come first and all status words follow. Word order is reversed: the lowest word address covers the highest-numbered group of sources. An enable word is an ordinary read/write register. To change one bit, software writes the whole word again. There are no set or clear aliases.

Top module: `pic_banked`

## Requirements
- R1: After reset every enable bit is 0, every enable word reads 0, and every `cpu_irq` bit is 0.
- R2: A write to an enable word stores the full 32-bit `bus_wdata`. A later read of that word returns the value written.
- R3: Processor k's window starts at byte address k·8·N_WORDS. Byte offsets 0 to 4·N_WORDS−4 in the window are enable words. The next N_WORDS words are status words. Bits [1:0] of the address are ignored.
- R4: Word slot j of either kind (j = 0 is the lowest address) covers sources (N_WORDS−1−j)·32 to (N_WORDS−1−j)·32+31, with source bit b of the group in data bit b.
- R5: A status word returns the synchronised raw level of its sources whatever the enables are. Every processor's window returns the same status.
- R6: Status words are read-only. A write to a status offset changes neither any enable word nor any status read nor any output.
- R7: A processor's line responds only to its own enable bank. Enabling a source for one processor leaves the other processor's line unchanged.
- R8: `cpu_irq[k]` is registered and equals the OR over all sources of (synchronised level AND processor k's enable). It changes on the clock edge after the edge that writes an enable word.
- R9: Reads of addresses beyond the last processor's window return 0. Writes there change nothing.
- R10: A change on `irq_src` reaches `cpu_irq` on the third rising clock edge after it: two synchroniser stages plus the output register.
- R11: A read returns its data in `bus_rdata` after the rising edge that samples `bus_rd`. `bus_rdata` keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_WORDS·32 | Level-sensitive interrupt sources, bit i = source i |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | N_CPUS | Per-processor interrupt request |

## Verification
The bench builds the block with its defaults: four words per bank (128 sources), two processors and an 8-bit address. With four groups, the reversed word order has to map correctly for both the first and the last slot. The second processor's window sits at 0x20, so a fault in the window stride shows up as a read or write landing in the wrong bank. The 8-bit address leaves 0xC0 bytes above the windows, which are used to check that out-of-range reads return zero and out-of-range writes have no effect.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Decoded bus address
    typedef struct packed {
        logic       hit;   // inside some processor window
        logic       stat;  // status half of the window
        logic [7:0] cpu;   // processor index
        logic [7:0] grp;   // source group (group g = sources g*32..g*32+31)
    } dec_t;

    // Word slot inside a half-window to source group: reversed order
    function automatic int unsigned slot_to_group(int unsigned slot, int unsigned n);
        return n - 1 - slot;
    endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [1:0]   warm_q;   // cycles since reset, saturating (checking aid)

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    // R10
    sync_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pic_bank.sv
module pic_bank
    import pic_pkg::*;
#(
    parameter int unsigned N_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_WORDS-1:0]       we,
    input  word_t                    wdata,
    input  logic [N_WORDS-1:0][31:0] stat,
    output logic [N_WORDS-1:0][31:0] en_q,
    output logic                     irq_o
);
    logic pend_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            for (int unsigned g = 0; g < N_WORDS; g++) begin
                if (we[g]) en_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        pend_any = 1'b0;
        for (int unsigned g = 0; g < N_WORDS; g++) begin
            pend_any = pend_any | (|(stat[g] & en_q[g]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pend_any;
    end

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        pend_any |=> irq_o);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_any |=> !irq_o);

    // R6
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we == '0) |=> $stable(en_q));

    for (genvar g = 0; g < N_WORDS; g++) begin : g_wchk
        // R2
        en_store_chk: assert property (@(posedge clk) disable iff (rst)
            we[g] |=> (en_q[g] == $past(wdata)));
    end

endmodule

// File: rtl/pic_regif.sv
module pic_regif
    import pic_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned N_CPUS  = 2,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  bus_wr,
    input  logic                                  bus_rd,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [N_CPUS-1:0][N_WORDS-1:0][31:0]  en_all,
    input  logic [N_WORDS-1:0][31:0]              stat,
    output logic [N_CPUS-1:0][N_WORDS-1:0]        we,
    output word_t                                 bus_rdata
);
    localparam int unsigned WIN = 2 * N_WORDS;

    dec_t        dec;
    int unsigned widx, cidx, off, slot;
    word_t       rsel;

    always_comb begin
        widx     = 32'(bus_addr[ADDR_W-1:2]);
        cidx     = widx / WIN;
        off      = widx % WIN;
        dec.hit  = (cidx < N_CPUS);
        dec.stat = (off >= N_WORDS);
        slot     = dec.stat ? (off - N_WORDS) : off;
        dec.cpu  = 8'(cidx);
        dec.grp  = 8'(slot_to_group(slot, N_WORDS));
    end

    always_comb begin
        we   = '0;
        rsel = '0;
        for (int unsigned c = 0; c < N_CPUS; c++) begin
            for (int unsigned g = 0; g < N_WORDS; g++) begin
                if (dec.hit && dec.cpu == 8'(c) && dec.grp == 8'(g)) begin
                    we[c][g] = bus_wr && !dec.stat;
                    rsel     = dec.stat ? stat[g] : en_all[c][g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rsel;
    end

    // R6
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.stat) |-> (we == '0));

    // R9
    oob_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !dec.hit) |-> (we == '0));

    // R9
    oob_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !dec.hit) |=> (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/pic_banked.sv
module pic_banked
    import pic_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned N_CPUS  = 2,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_WORDS*32-1:0]     irq_src,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [N_CPUS-1:0]         cpu_irq
);
    localparam int unsigned N_SRC = N_WORDS * WORD_W;

    logic [N_SRC-1:0]                     src_sync;
    logic [N_WORDS-1:0][31:0]             stat;
    logic [N_CPUS-1:0][N_WORDS-1:0][31:0] en_all;
    logic [N_CPUS-1:0][N_WORDS-1:0]       we;

    pic_sync #(.W(N_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (src_sync)
    );

    assign stat = src_sync;

    pic_regif #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .en_all    (en_all),
        .stat      (stat),
        .we        (we),
        .bus_rdata (bus_rdata)
    );

    for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
        pic_bank #(.N_WORDS(N_WORDS)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we[c]),
            .wdata (bus_wdata),
            .stat  (stat),
            .en_q  (en_all[c]),
            .irq_o (cpu_irq[c])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_irq == '0));

    // R7
    one_bank_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(we) <= 1);

endmodule

// File: tb/pic_banked_test.sv
module pic_banked_test;
    localparam int unsigned NW = 4;
    localparam int unsigned NC = 2;
    localparam int unsigned AW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [NW*32-1:0]  irq_src;
    logic              bus_wr, bus_rd;
    logic [AW-1:0]     bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     cpu_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pic_banked #(.N_WORDS(NW), .N_CPUS(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    // Address helpers, straight from R3/R4
    function automatic logic [AW-1:0] en_addr(int c, int src);
        return AW'(c * 8 * NW + 4 * (NW - 1 - src / 32));
    endfunction
    function automatic logic [AW-1:0] st_addr(int c, int src);
        return AW'(c * 8 * NW + 4 * NW + 4 * (NW - 1 - src / 32));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) begin
                bus_read(en_addr(c, g * 32), v);
                chk("R1 enable word after reset", v, 32'h0);
            end
    endtask

    task automatic t_rw();
        logic [31:0] v;
        bus_write(8'h00, 32'hA5A5_0F0F);
        bus_write(8'h28, 32'h1234_5678);
        bus_read(8'h00, v);
        chk("R2 cpu0 slot0 readback", v, 32'hA5A5_0F0F);
        bus_read(8'h28, v);
        chk("R3 cpu1 slot2 readback", v, 32'h1234_5678);
        bus_read(8'h08, v);
        chk("R3 cpu0 slot2 untouched", v, 32'h0);
        bus_read(8'h20, v);
        chk("R3 cpu1 slot0 untouched", v, 32'h0);
        bus_read(8'h29, v);
        chk("R3 low address bits ignored", v, 32'h1234_5678);
        bus_write(8'h00, 32'h0);
        bus_write(8'h28, 32'h0);
        bus_read(8'h00, v);
        chk("R2 whole-word rewrite clears", v, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk);
        irq_src[5] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(st_addr(0, 5), v);
        chk("R4 source 5 in last status slot", v, 32'h20);
        bus_read(st_addr(0, 100), v);
        chk("R4 first status slot quiet", v, 32'h0);
        chk("R5 no enable, no output", 32'(cpu_irq), 32'h0);
        irq_src[100] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(8'h10, v);
        chk("R4 source 100 in first status slot", v, 32'h10);
        bus_read(st_addr(1, 5), v);
        chk("R5 cpu1 sees same status", v, 32'h20);
    endtask

    task automatic t_stat_ro();
        logic [31:0] v;
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_read(8'h1C, v);
        chk("R6 status unchanged by write", v, 32'h20);
        bus_read(8'h0C, v);
        chk("R6 enable unchanged by status write", v, 32'h0);
        bus_read(8'h20, v);
        chk("R6 cpu1 enable unchanged", v, 32'h0);
        chk("R6 outputs unchanged", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_output();
        bus_write(en_addr(0, 5), 32'h20);
        chk("R8 no change on write edge", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        chk("R8 cpu0 asserts one edge later", 32'(cpu_irq[0]), 32'h1);
        chk("R7 cpu1 stays low", 32'(cpu_irq[1]), 32'h0);
    endtask

    task automatic t_latency();
        irq_src[5] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 still high after two edges", 32'(cpu_irq[0]), 32'h1);
        @(negedge clk);
        chk("R10 low after third edge", 32'(cpu_irq[0]), 32'h0);
        bus_write(en_addr(1, 100), 32'h10);
        @(negedge clk);
        chk("R7 cpu1 follows own bank", 32'(cpu_irq[1]), 32'h1);
        chk("R7 cpu0 ignores cpu1 bank", 32'(cpu_irq[0]), 32'h0);
    endtask

    task automatic t_oob();
        logic [31:0] v;
        bus_read(8'h40, v);
        chk("R9 read 0x40", v, 32'h0);
        bus_read(8'hFC, v);
        chk("R9 read 0xFC", v, 32'h0);
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'h80, 32'hFFFF_FFFF);
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < NW; j++) begin
                logic [31:0] e;
                e = 32'h0;
                if (c == 0 && j == NW - 1) e = 32'h20;
                if (c == 1 && j == 0)      e = 32'h10;
                bus_read(AW'(c * 8 * NW + 4 * j), v);
                chk("R9 enables untouched by out-of-range write", v, e);
            end
        chk("R9 outputs untouched", 32'(cpu_irq), 32'h2);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        bus_read(8'h20, v);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds without read", bus_rdata, 32'h10);
    endtask

    initial begin
        rst = 1'b1; irq_src = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rw();
        t_status();
        t_stat_ro();
        t_output();
        t_latency();
        t_oob();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule